// File: doc/BRIEF.md
# Non-uniform sector decoder with write-protection gate

This block sits between the command logic of a flash-style array and its program/erase engine. It turns a word address into a sector number for an array with thirty-one large sectors and four small boot sectors at the top of the address space. It keeps one protection flag per sector. For each program or erase request it reports which sectors may actually be touched, or that the request is refused.

Protection is changed by control strobes whose meaning is picked by address bits 6, 1 and 0. A protect strobe marks the addressed sector. An unprotect strobe clears every flag at once, but only when all flags are already set. A level input stands in for the high-voltage reset condition: while it is high, protection is masked, and the stored flags are untouched. A verify request reads one sector's flag back as a byte.

Erases are built up in a small state machine. ST_IDLE accepts single requests and moves to ST_COLLECT on the first sector selection. ST_COLLECT gathers further sectors and moves to ST_ISSUE on the launch strobe. ST_ISSUE evaluates the gathered set against protection and returns to ST_IDLE.

Top module: `sect_guard`

## Requirements
- R1: When address bits [19:15] are not all ones, `sect_idx` equals the value of those bits (sectors 0 to 30, each 32K words).
- R2: When address bits [19:15] are all ones, `sect_idx` is decided by address bits [14:12]. Values 0 to 3 give 31 (16K words), 4 gives 32, 5 gives 33, and 6 or 7 give 34 (8K words).
- R3: In ST_IDLE, `prot_stb` with addr[6]=0, addr[1]=1, addr[0]=0 sets the flag of the addressed sector. A strobe with any other selector pattern changes no flag.
- R4: In ST_IDLE, `prot_stb` with addr[6]=1, addr[1]=1, addr[0]=0 clears all 35 flags in one cycle when every flag was set.
- R5: An unprotect strobe while any flag is clear changes no flag. It sets `unprot_err`, which then stays high until reset.
- R6: `pgm_req` in ST_IDLE gives, one cycle later, `go_valid` with `go_mask` holding only the bit of the addressed sector if that sector is not blocked. Otherwise it gives `go_reject`.
- R7: `ers_sel` strobes add the addressed sector to an erase set (ST_IDLE to ST_COLLECT). `ers_go` moves to ST_ISSUE, and on the following cycle `go_mask` holds the set minus blocked sectors with `go_valid`. If nothing is left, `go_reject` is raised instead.
- R8: `ers_all` adds every sector to the erase set (chip erase). Protected sectors are left out of `go_mask`, and a chip erase with all sectors protected is rejected.
- R9: While `tmp_unlock` is high no sector is blocked. After it drops, the earlier flags block again and verify still shows them.
- R10: `vfy_req` in ST_IDLE gives, one cycle later, `vfy_valid` with `vfy_data` = 01h for a protected sector and 00h otherwise.
- R11: After reset all flags are clear, `unprot_err`, `go_valid`, `go_reject` and `vfy_valid` are low, and the machine is in ST_IDLE.
- R12: Outside ST_IDLE, `prot_stb`, `pgm_req` and `vfy_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 20 | Word address; bits 6, 1, 0 also select the protection action |
| prot_stb | input | 1 | Protection-control strobe |
| pgm_req | input | 1 | Program request at `addr` |
| ers_sel | input | 1 | Add the sector at `addr` to the erase set |
| ers_all | input | 1 | Add all sectors to the erase set |
| ers_go | input | 1 | Launch the collected erase |
| vfy_req | input | 1 | Protect-verify read at `addr` |
| tmp_unlock | input | 1 | Temporary unprotect level |
| sect_idx | output | 6 | Sector number of `addr` |
| go_valid | output | 1 | Request granted (one-cycle pulse) |
| go_mask | output | 35 | Sectors the granted operation may touch |
| go_reject | output | 1 | Request refused (one-cycle pulse) |
| vfy_valid | output | 1 | Verify result valid |
| vfy_data | output | 8 | Verify byte |
| unprot_err | output | 1 | Sticky illegal-unprotect flag |

## Verification
The bench probes the boot-region boundaries at 16K, 20K and 24K words into the top block and the last word of sector 30. A decoder that got a boundary wrong would name a neighbouring sector there. It tries an unprotect with one flag clear, where a lax design would wipe protection or forget the sticky error. It checks the temporary unlock both ways: a design that wrote the flags instead of masking them would show 00h on verify after release. It also checks erase sets that are fully, partly and not at all protected, and strobes sent during ST_COLLECT that must leave no trace. A seeded random phase then mixes every operation against a reference model.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_ISSUE   = 2'd2
    } sg_state_t;

    localparam logic [7:0] VFY_SET   = 8'h01;
    localparam logic [7:0] VFY_CLEAR = 8'h00;
endpackage

// File: rtl/sg_decode.sv
module sg_decode #(
    parameter int HI_W  = 5,
    parameter int IDX_W = 6
) (
    input  logic [HI_W+2:0]  top_bits,
    output logic [IDX_W-1:0] idx
);
    localparam int NUM_MAIN = (1 << HI_W) - 1;

    logic [HI_W-1:0] blk;
    logic [2:0]      sub;

    assign blk = top_bits[HI_W+2:3];
    assign sub = top_bits[2:0];

    always_comb begin
        if (blk != '1) begin
            idx = IDX_W'(blk);
        end else if (!sub[2]) begin
            idx = IDX_W'(NUM_MAIN);
        end else begin
            unique case (sub[1:0])
                2'd0:    idx = IDX_W'(NUM_MAIN + 1);
                2'd1:    idx = IDX_W'(NUM_MAIN + 2);
                default: idx = IDX_W'(NUM_MAIN + 3);
            endcase
        end
    end

    always_comb begin
        AST_IDX_RANGE: assert (int'(idx) <= NUM_MAIN + 3); // R2
    end
endmodule

// File: rtl/sg_prot_reg.sv
module sg_prot_reg #(
    parameter int NUM_SECT = 35,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_try,
    output logic [NUM_SECT-1:0] prot,
    output logic                unprot_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot       <= '0;
            unprot_err <= 1'b0;
        end else if (set_en) begin
            prot <= prot | (NUM_SECT'(1) << set_idx);
        end else if (clr_try) begin
            if (&prot) prot       <= '0;
            else       unprot_err <= 1'b1;
        end
    end

    AST_UNPROT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_try && !set_en && (&prot)) |=> (prot == '0)); // R4
    AST_UNPROT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_try && !set_en && !(&prot)) |=> ($stable(prot) && unprot_err)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        unprot_err |=> unprot_err); // R5
    AST_PROTECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ($countones(prot) >= $countones($past(prot)))); // R3
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
    import sg_pkg::*;
#(
    parameter int NUM_SECT = 35,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prot_stb,
    input  logic                sel_a6,
    input  logic                sel_a1,
    input  logic                sel_a0,
    input  logic                pgm_req,
    input  logic                ers_sel,
    input  logic                ers_all,
    input  logic                ers_go,
    input  logic                vfy_req,
    input  logic                tmp_unlock,
    input  logic [IDX_W-1:0]    idx,
    input  logic [NUM_SECT-1:0] prot,
    output logic                set_en,
    output logic                clr_try,
    output logic                go_valid,
    output logic [NUM_SECT-1:0] go_mask,
    output logic                go_reject,
    output logic                vfy_valid,
    output logic [7:0]          vfy_data
);
    sg_state_t state, state_nx;

    logic [NUM_SECT-1:0] sel_q;
    logic [NUM_SECT-1:0] onehot, blocked, add_vec, issue_eff;
    logic in_idle, sel_ok, pgm_go, ers_hit, vfy_go;

    assign onehot    = NUM_SECT'(1) << idx;
    assign blocked   = tmp_unlock ? '0 : prot;
    assign add_vec   = ers_all ? '1 : onehot;
    assign issue_eff = sel_q & ~blocked;
    assign in_idle   = (state == ST_IDLE);
    assign sel_ok    = sel_a1 & ~sel_a0;

    assign set_en  = in_idle & prot_stb & sel_ok & ~sel_a6;
    assign clr_try = in_idle & prot_stb & sel_ok &  sel_a6;
    assign pgm_go  = in_idle & ~prot_stb & pgm_req;
    assign ers_hit = (ers_sel | ers_all) &
                     ((in_idle & ~prot_stb & ~pgm_req) | (state == ST_COLLECT));
    assign vfy_go  = in_idle & ~prot_stb & ~pgm_req & ~ers_sel & ~ers_all & vfy_req;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (ers_hit) state_nx = ST_COLLECT;
            ST_COLLECT: if (ers_go)  state_nx = ST_ISSUE;
            ST_ISSUE:   state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel_q <= '0;
        end else begin
            state <= state_nx;
            if (ers_hit) sel_q <= in_idle ? add_vec : (sel_q | add_vec);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_valid  <= 1'b0;
            go_mask   <= '0;
            go_reject <= 1'b0;
            vfy_valid <= 1'b0;
            vfy_data  <= VFY_CLEAR;
        end else begin
            go_valid  <= 1'b0;
            go_mask   <= '0;
            go_reject <= 1'b0;
            vfy_valid <= 1'b0;
            vfy_data  <= VFY_CLEAR;
            if (pgm_go) begin
                if ((onehot & ~blocked) != '0) begin
                    go_valid <= 1'b1;
                    go_mask  <= onehot;
                end else begin
                    go_reject <= 1'b1;
                end
            end else if (state == ST_ISSUE) begin
                if (issue_eff != '0) begin
                    go_valid <= 1'b1;
                    go_mask  <= issue_eff;
                end else begin
                    go_reject <= 1'b1;
                end
            end else if (vfy_go) begin
                vfy_valid <= 1'b1;
                vfy_data  <= (prot[idx]) ? VFY_SET : VFY_CLEAR;
            end
        end
    end

    AST_GRANT_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        go_valid |-> ((go_mask & $past(prot) & {NUM_SECT{!$past(tmp_unlock)}}) == '0)); // R9
    AST_PGM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (go_valid && $past(state == ST_IDLE)) |-> ($countones(go_mask) == 1)); // R6
    AST_ISSUE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE) |=> (state == ST_IDLE)); // R7
    AST_BUSY_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !(set_en || clr_try)); // R12
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_valid, go_reject, vfy_valid})); // R10
endmodule

// File: rtl/sect_guard.sv
module sect_guard #(
    parameter  int ADDR_W   = 20,
    parameter  int BLK_W    = 15,
    localparam int HI_W     = ADDR_W - BLK_W,
    localparam int NUM_SECT = (1 << HI_W) + 3,
    localparam int IDX_W    = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                prot_stb,
    input  logic                pgm_req,
    input  logic                ers_sel,
    input  logic                ers_all,
    input  logic                ers_go,
    input  logic                vfy_req,
    input  logic                tmp_unlock,
    output logic [IDX_W-1:0]    sect_idx,
    output logic                go_valid,
    output logic [NUM_SECT-1:0] go_mask,
    output logic                go_reject,
    output logic                vfy_valid,
    output logic [7:0]          vfy_data,
    output logic                unprot_err
);
    logic [NUM_SECT-1:0] prot;
    logic set_en, clr_try;
    logic addr_unused;

    assign addr_unused = ^{addr[BLK_W-4:7], addr[5:2]};

    sg_decode #(.HI_W(HI_W), .IDX_W(IDX_W)) u_dec (
        .top_bits (addr[ADDR_W-1:BLK_W-3]),
        .idx      (sect_idx)
    );

    sg_prot_reg #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_prot (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (set_en),
        .set_idx    (sect_idx),
        .clr_try    (clr_try),
        .prot       (prot),
        .unprot_err (unprot_err)
    );

    sg_ctrl #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_stb   (prot_stb),
        .sel_a6     (addr[6]),
        .sel_a1     (addr[1]),
        .sel_a0     (addr[0]),
        .pgm_req    (pgm_req),
        .ers_sel    (ers_sel),
        .ers_all    (ers_all),
        .ers_go     (ers_go),
        .vfy_req    (vfy_req),
        .tmp_unlock (tmp_unlock),
        .idx        (sect_idx),
        .prot       (prot),
        .set_en     (set_en),
        .clr_try    (clr_try),
        .go_valid   (go_valid),
        .go_mask    (go_mask),
        .go_reject  (go_reject),
        .vfy_valid  (vfy_valid),
        .vfy_data   (vfy_data)
    );
endmodule

// File: tb/sect_guard_test.sv
`timescale 1ns/1ps
module sect_guard_test;
    localparam int NS = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic prot_stb = 0, pgm_req = 0, ers_sel = 0, ers_all = 0, ers_go = 0, vfy_req = 0, tmp_unlock = 0;
    logic [5:0]    sect_idx;
    logic          go_valid, go_reject, vfy_valid, unprot_err;
    logic [NS-1:0] go_mask;
    logic [7:0]    vfy_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [NS-1:0] prot_m = '0;
    logic          err_m  = 1'b0;

    always #2 clk = ~clk;

    sect_guard uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .prot_stb(prot_stb), .pgm_req(pgm_req),
        .ers_sel(ers_sel), .ers_all(ers_all), .ers_go(ers_go), .vfy_req(vfy_req),
        .tmp_unlock(tmp_unlock), .sect_idx(sect_idx), .go_valid(go_valid), .go_mask(go_mask),
        .go_reject(go_reject), .vfy_valid(vfy_valid), .vfy_data(vfy_data), .unprot_err(unprot_err)
    );

    function automatic int exp_idx(input logic [19:0] a);
        if (a[19:15] != 5'h1F) return int'(a[19:15]);
        if (!a[14])            return 31;
        if (a[13:12] == 2'd0)  return 32;
        if (a[13:12] == 2'd1)  return 33;
        return 34;
    endfunction

    function automatic logic [19:0] sect_base(input int s);
        if (s < 31)  return 20'(s) << 15;
        if (s == 31) return 20'hF8000;
        if (s == 32) return 20'hFC000;
        if (s == 33) return 20'hFD000;
        return 20'hFE000;
    endfunction

    function automatic logic [NS-1:0] blocked_m();
        return tmp_unlock ? '0 : prot_m;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_dec(input logic [19:0] a, input string req);
        @(negedge clk);
        addr = a;
        #0.5;
        check(req, 64'(sect_idx), 64'(exp_idx(a)));
    endtask

    task automatic do_prot(input logic [19:0] a, input string req);
        @(negedge clk);
        addr = a; prot_stb = 1;
        @(negedge clk);
        prot_stb = 0;
        if (a[1] && !a[0]) begin
            if (!a[6]) prot_m[exp_idx(a)] = 1'b1;
            else if (&prot_m) prot_m = '0;
            else err_m = 1'b1;
        end
        check(req, 64'(unprot_err), 64'(err_m));
    endtask

    task automatic do_pgm(input logic [19:0] a, input string req);
        logic [NS-1:0] oh;
        @(negedge clk);
        addr = a; pgm_req = 1;
        @(negedge clk);
        pgm_req = 0;
        oh = NS'(1) << exp_idx(a);
        if ((oh & ~blocked_m()) != '0) begin
            check(req, {go_valid, go_reject, 62'(go_mask)}, {2'b10, 62'(oh)});
        end else begin
            check(req, {go_valid, go_reject, 62'(go_mask)}, {2'b01, 62'd0});
        end
    endtask

    task automatic do_vfy(input int s, input string req);
        @(negedge clk);
        addr = sect_base(s); vfy_req = 1;
        @(negedge clk);
        vfy_req = 0;
        check(req, {vfy_valid, vfy_data}, {1'b1, 7'd0, prot_m[s]});
    endtask

    task automatic do_erase(input logic [NS-1:0] set, input bit all, input string req);
        logic [NS-1:0] eff;
        if (all) begin
            @(negedge clk);
            ers_all = 1;
        end else begin
            for (int s = 0; s < NS; s++) begin
                if (set[s]) begin
                    @(negedge clk);
                    addr = sect_base(s); ers_sel = 1;
                end
            end
        end
        @(negedge clk);
        ers_sel = 0; ers_all = 0; ers_go = 1;
        @(negedge clk);
        ers_go = 0;
        @(negedge clk);
        eff = (all ? {NS{1'b1}} : set) & ~blocked_m();
        if (eff != '0) check(req, {go_valid, go_reject, 62'(go_mask)}, {2'b10, 62'(eff)});
        else           check(req, {go_valid, go_reject, 62'(go_mask)}, {2'b01, 62'd0});
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 outputs", {go_valid, go_reject, vfy_valid, unprot_err}, 4'b0000);
        rst_n = 1;
        do_vfy(0, "R11 flags clear");
        do_vfy(34, "R11 flags clear");

        // R1 / R2 decode
        chk_dec(20'h00000, "R1 first");
        chk_dec(20'h7BFFF, "R1 mid");
        chk_dec(20'hF7FFF, "R1 last main");
        chk_dec(20'hF8000, "R2 boot 31 low");
        chk_dec(20'hFBFFF, "R2 boot 31 high");
        chk_dec(20'hFC000, "R2 boot 32");
        chk_dec(20'hFCFFF, "R2 boot 32 end");
        chk_dec(20'hFD000, "R2 boot 33");
        chk_dec(20'hFE000, "R2 boot 34");
        chk_dec(20'hFFFFF, "R2 boot 34 end");

        // R5 illegal unprotect
        do_prot(20'h00042, "R5 err set");
        do_vfy(0, "R5 no change");

        // R3 protect and bad selector
        do_prot(sect_base(3) | 20'h2, "R3 protect");
        do_prot(sect_base(4) | 20'h3, "R3 bad selector");
        do_vfy(3, "R3 verify set");
        do_vfy(4, "R3 verify untouched");

        // R6 / R9 program
        do_pgm(sect_base(3), "R6 reject");
        do_pgm(sect_base(4), "R6 grant");
        @(negedge clk); tmp_unlock = 1;
        do_pgm(sect_base(3), "R9 override");
        @(negedge clk); tmp_unlock = 0;
        do_vfy(3, "R9 flag kept");
        do_pgm(sect_base(3), "R9 restored");

        // R7 multi-sector erase, R10 verify byte
        do_erase((NS'(1) << 3) | (NS'(1) << 4) | (NS'(1) << 34), 0, "R7 partial");
        do_erase(NS'(1) << 3, 0, "R7 all blocked");
        do_erase('0, 1, "R8 chip skip");

        // R12 strobes ignored while collecting
        @(negedge clk); addr = sect_base(5); ers_sel = 1;
        @(negedge clk); ers_sel = 0; prot_stb = 1; addr = sect_base(5) | 20'h2;
        @(negedge clk); prot_stb = 0; vfy_req = 1; pgm_req = 1;
        @(negedge clk); vfy_req = 0; pgm_req = 0;
        check("R12 no output", {go_valid, go_reject, vfy_valid}, 3'b000);
        ers_go = 1;
        @(negedge clk); ers_go = 0;
        @(negedge clk);
        check("R12 erase intact", {go_valid, 62'(go_mask)}, {1'b1, 62'(NS'(1) << 5)});
        do_vfy(5, "R12 no protect");

        // R8 chip erase fully protected, R4 unprotect
        for (int s = 0; s < NS; s++) do_prot(sect_base(s) | 20'h2, "R3 protect all");
        do_erase('0, 1, "R8 chip reject");
        do_prot(20'h00042, "R4 unprotect / R5 sticky");
        do_vfy(0, "R4 cleared");
        do_vfy(31, "R4 cleared");
        do_vfy(34, "R4 cleared");
        do_vfy(10, "R10 verify 00");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [19:0] ra;
            op = int'($urandom % 7);
            ra = 20'($urandom);
            case (op)
                0: do_prot((ra & 20'hFFFBC) | 20'h2, "R3 random protect");
                1: do_prot(ra, "R5 random strobe");
                2: do_pgm(ra, "R6 random program");
                3: do_vfy(int'($urandom % NS), "R10 random verify");
                4: begin
                    logic [NS-1:0] st;
                    st = NS'({$urandom, $urandom}) & NS'({$urandom, $urandom});
                    if (st == '0) st[0] = 1'b1;
                    do_erase(st, 0, "R7 random erase");
                end
                5: do_erase('0, 1, "R8 random chip");
                default: begin @(negedge clk); tmp_unlock = ~tmp_unlock; end
            endcase
            if (i % 50 == 0) chk_dec(ra, "R1 random decode");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule